// File: doc/BRIEF.md
# Scan Chain Flush Integrity Checker

This block proves that one scan chain can carry data from its head to its tail before any structural test pattern is trusted. When started, it holds the chain's shift enable high and drives a repeating two-zeros, two-ones stimulus into the chain head. No functional capture clock is ever requested. The block knows the chain length `CHAIN_LEN` as a build parameter. It ignores the chain tail until the chain has filled from its unknown contents. After that, it compares every tail bit against the stimulus it sent `CHAIN_LEN` cycles earlier.

The number of compared cycles is given on an input and is never fewer than four, so both values and both transition directions are seen. When the flush ends, the block pulses `done`. It then holds the verdict and the diagnostics until the next start. The diagnostics are the index of the first compared cycle that went wrong, and a flag with a value that tell whether every compared tail bit was one constant, which is the signature of a stuck shift path.

Top module: `scan_flush_checker`

## Requirements
- R1: After reset, `shift_en`, `chain_in`, `done`, `flush_pass`, `flush_fail`, `stuck_det`, `stuck_val` are 0 and `first_err_idx` is 0.
- R2: A `start` seen while idle raises `shift_en` in the next cycle. `shift_en` then stays high for exactly `CHAIN_LEN` + L cycles, where L is the checked-cycle count. `done` is high for exactly one cycle, the first cycle with `shift_en` low again.
- R3: In flush cycle k (k = 0 is the first cycle with `shift_en` high), `chain_in` equals bit 1 of k, giving the sequence 0,0,1,1 repeating.
- R4: The tail bit seen in flush cycle j is compared only when j >= `CHAIN_LEN`, and it is compared against the `chain_in` value of cycle j - `CHAIN_LEN`. Tail values in earlier cycles have no effect on any result.
- R5: At `done`, `flush_pass`=1 and `flush_fail`=0 if all L compared bits matched; otherwise `flush_fail`=1 and `flush_pass`=0.
- R6: On failure, `first_err_idx` holds j - `CHAIN_LEN` for the earliest mismatching cycle j. On pass it holds 0.
- R7: `stuck_det`=1 when all L compared tail bits are the same value, and `stuck_val` then holds that value. Otherwise both are 0.
- R8: The results change only at the end of a flush. They are cleared to 0 in the first flush cycle after an accepted start and then hold until the next accepted start.
- R9: A `start` pulse while a flush is running is ignored and does not lengthen or restart the flush.
- R10: The checked-cycle count L equals `check_len`, except that values below 4 are raised to 4. L is latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a flush when idle |
| check_len | input | CNT_W | Requested number of compared cycles |
| chain_out | input | 1 | Tail bit of the chain under test |
| shift_en | output | 1 | Scan-enable to the chain, high for the whole flush |
| chain_in | output | 1 | Stimulus bit into the chain head |
| done | output | 1 | One-cycle end-of-flush pulse |
| flush_pass | output | 1 | Every compared bit matched |
| flush_fail | output | 1 | At least one compared bit mismatched |
| first_err_idx | output | CNT_W | Compared-cycle index of the first mismatch |
| stuck_det | output | 1 | All compared tail bits were one constant |
| stuck_val | output | 1 | That constant value |

## Verification
After the accepting edge, `shift_en` and the first stimulus bit appear one cycle later. The tail compared in flush cycle j reflects the head bit of cycle j - `CHAIN_LEN`, because the bench chain model has `CHAIN_LEN` registers. The verdict and diagnostics become visible in the same cycle as `done`, which is the first cycle after the last compared cycle. The bench samples on the falling edge and walks the flush cycle by cycle. It checks the head bit of every cycle and counts the enable length. It reads the results in the cycle where `done` is seen, and it reads them again one cycle later to confirm that `done` has fallen and the results have held.

// File: rtl/scan_flush_pkg.sv
package scan_flush_pkg;

   typedef enum logic {
      FL_IDLE = 1'b0,
      FL_RUN  = 1'b1
   } flush_state_e;

   localparam int unsigned MIN_CHECK = 4;

   // Period-4 stimulus: phase 0,1 -> 0 ; phase 2,3 -> 1
   function automatic logic flush_bit(input logic [1:0] phase);
      return phase[1];
   endfunction

endpackage

// File: rtl/flush_seq_ctrl.sv
module flush_seq_ctrl
   import scan_flush_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 16,
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned TOT_W     = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] check_len,
   output logic             run,
   output logic [TOT_W-1:0] cyc,
   output logic             start_acc,
   output logic             last,
   output logic             done
);

   flush_state_e     state_q;
   logic [TOT_W-1:0] cyc_q;
   logic [TOT_W-1:0] total_q;
   logic             done_q;
   logic [CNT_W-1:0] eff_len;

   // R10: raise short requests to the minimum window
   assign eff_len   = (check_len < CNT_W'(MIN_CHECK)) ? CNT_W'(MIN_CHECK) : check_len;
   assign run       = (state_q == FL_RUN);
   assign start_acc = start && (state_q == FL_IDLE);
   assign last      = run && (cyc_q == total_q - TOT_W'(1));
   assign cyc       = cyc_q;
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FL_IDLE;
         cyc_q   <= '0;
         total_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (start_acc) begin
            state_q <= FL_RUN;
            cyc_q   <= '0;
            total_q <= TOT_W'(CHAIN_LEN) + TOT_W'(eff_len);
         end else if (run) begin
            cyc_q <= cyc_q + TOT_W'(1);
            if (last) begin
               state_q <= FL_IDLE;
            end
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2

   AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cyc_q < total_q)); // R2

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !last && start) |=> (run && cyc_q == $past(cyc_q) + TOT_W'(1))); // R9

endmodule

// File: rtl/flush_stim_gen.sv
module flush_stim_gen
   import scan_flush_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 16,
   parameter int unsigned TOT_W     = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TOT_W-1:0] cyc,
   output logic             chain_in,
   output logic             exp_bit,
   output logic             chk_en,
   output logic [TOT_W-1:0] chk_idx
);

   localparam int unsigned LAT_PHASE = CHAIN_LEN % 4;

   logic [1:0] exp_phase;

   // R3: stimulus phase follows the low bits of the flush cycle
   assign chain_in = run && flush_bit(cyc[1:0]);

   // R4: expected tail = stimulus CHAIN_LEN cycles back; period 4 so only
   // the latency modulo 4 matters
   generate
      if (LAT_PHASE == 0) begin : g_aligned
         assign exp_phase = cyc[1:0];
      end else begin : g_offset
         assign exp_phase = cyc[1:0] - 2'(LAT_PHASE);
      end
   endgenerate

   assign exp_bit = flush_bit(exp_phase);
   assign chk_en  = run && (cyc >= TOT_W'(CHAIN_LEN));
   assign chk_idx = cyc - TOT_W'(CHAIN_LEN);

   AST_STIM_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cyc >= TOT_W'(4)) |-> (chain_in == $past(chain_in, 4))); // R3

endmodule

// File: rtl/flush_compare.sv
module flush_compare #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned TOT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_acc,
   input  logic             chk_en,
   input  logic             last,
   input  logic             exp_bit,
   input  logic             obs_bit,
   input  logic [TOT_W-1:0] chk_idx,
   output logic             flush_pass,
   output logic             flush_fail,
   output logic [CNT_W-1:0] first_err_idx,
   output logic             stuck_det,
   output logic             stuck_val
);

   logic             err_q, seen_q, same_q, ref_q;
   logic [CNT_W-1:0] idx_q;
   logic             mism, err_now, same_now, ref_now;
   logic [CNT_W-1:0] idx_now;

   assign mism     = chk_en && (obs_bit != exp_bit);
   assign err_now  = err_q || mism;
   assign idx_now  = err_q ? idx_q : (mism ? CNT_W'(chk_idx) : '0);
   assign ref_now  = seen_q ? ref_q : obs_bit;
   assign same_now = seen_q ? (same_q && (obs_bit == ref_q)) : 1'b1;

   // running trackers over the compared window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         seen_q <= 1'b0;
         same_q <= 1'b0;
         ref_q  <= 1'b0;
         idx_q  <= '0;
      end else if (start_acc) begin
         err_q  <= 1'b0;
         seen_q <= 1'b0;
         same_q <= 1'b0;
         ref_q  <= 1'b0;
         idx_q  <= '0;
      end else if (chk_en) begin
         err_q  <= err_now;
         idx_q  <= idx_now;
         seen_q <= 1'b1;
         same_q <= same_now;
         ref_q  <= ref_now;
      end
   end

   // visible results: cleared on start, loaded once at the last cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_pass    <= 1'b0;
         flush_fail    <= 1'b0;
         first_err_idx <= '0;
         stuck_det     <= 1'b0;
         stuck_val     <= 1'b0;
      end else if (start_acc) begin
         flush_pass    <= 1'b0;
         flush_fail    <= 1'b0;
         first_err_idx <= '0;
         stuck_det     <= 1'b0;
         stuck_val     <= 1'b0;
      end else if (last) begin
         flush_pass    <= !err_now;
         flush_fail    <= err_now;
         first_err_idx <= idx_now;
         stuck_det     <= same_now;
         stuck_val     <= same_now && ref_now;
      end
   end

   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush_pass && flush_fail)); // R5

   AST_PASS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pass |-> (first_err_idx == '0)); // R6

   AST_STUCK_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_det |-> flush_fail); // R7

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!last && !start_acc) |=> ($stable(flush_pass) && $stable(flush_fail) &&
         $stable(first_err_idx) && $stable(stuck_det) && $stable(stuck_val))); // R8

endmodule

// File: rtl/scan_flush_checker.sv
module scan_flush_checker
   import scan_flush_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 16,
   parameter int unsigned CNT_W     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] check_len,
   input  logic             chain_out,
   output logic             shift_en,
   output logic             chain_in,
   output logic             done,
   output logic             flush_pass,
   output logic             flush_fail,
   output logic [CNT_W-1:0] first_err_idx,
   output logic             stuck_det,
   output logic             stuck_val
);

   localparam int unsigned TOT_W = $clog2(CHAIN_LEN + (2 ** CNT_W) + 1);

   generate
      if (CHAIN_LEN < 1) begin : g_bad_chain
         $error("scan_flush_checker: CHAIN_LEN must be at least 1");
      end
      if (CNT_W < 3 || CNT_W > 24) begin : g_bad_cnt
         $error("scan_flush_checker: CNT_W must lie in 3..24");
      end
   endgenerate

   logic             run, start_acc, last, exp_bit, chk_en;
   logic [TOT_W-1:0] cyc, chk_idx;

   flush_seq_ctrl #(
      .CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W), .TOT_W(TOT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .check_len(check_len),
      .run(run), .cyc(cyc), .start_acc(start_acc), .last(last), .done(done)
   );

   flush_stim_gen #(
      .CHAIN_LEN(CHAIN_LEN), .TOT_W(TOT_W)
   ) u_stim (
      .clk(clk), .rst_n(rst_n), .run(run), .cyc(cyc),
      .chain_in(chain_in), .exp_bit(exp_bit), .chk_en(chk_en), .chk_idx(chk_idx)
   );

   flush_compare #(
      .CNT_W(CNT_W), .TOT_W(TOT_W)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .chk_en(chk_en),
      .last(last), .exp_bit(exp_bit), .obs_bit(chain_out), .chk_idx(chk_idx),
      .flush_pass(flush_pass), .flush_fail(flush_fail),
      .first_err_idx(first_err_idx), .stuck_det(stuck_det), .stuck_val(stuck_val)
   );

   assign shift_en = run;

   AST_SE_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_en) |-> done); // R2

   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!shift_en && $past(shift_en))); // R2

endmodule

// File: tb/scan_flush_checker_test.sv
module scan_flush_checker_test;

   localparam int N  = 8;
   localparam int CW = 8;

   // mode: 0 healthy, 1 cell stuck 0, 2 cell stuck 1, 3 cell inverts, 4 extra cell
   typedef struct packed {
      logic [2:0]  mode;
      logic [3:0]  pos;
      logic [7:0]  flip;   // 255 = no transient flip
      logic [7:0]  clen;
      logic        e_pass;
      logic [7:0]  e_idx;
      logic        e_stk;
      logic        e_sv;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 4'd0, 8'd255, 8'd8,  1'b1, 8'd0, 1'b0, 1'b0},
      '{3'd1, 4'd3, 8'd255, 8'd8,  1'b0, 8'd2, 1'b1, 1'b0},
      '{3'd2, 4'd7, 8'd255, 8'd8,  1'b0, 8'd0, 1'b1, 1'b1},
      '{3'd3, 4'd2, 8'd255, 8'd6,  1'b0, 8'd0, 1'b0, 1'b0},
      '{3'd0, 4'd0, 8'd5,   8'd12, 1'b0, 8'd5, 1'b0, 1'b0},
      '{3'd4, 4'd0, 8'd255, 8'd8,  1'b0, 8'd2, 1'b0, 1'b0},
      '{3'd0, 4'd0, 8'd255, 8'd2,  1'b1, 8'd0, 1'b0, 1'b0},
      '{3'd0, 4'd0, 8'd255, 8'd20, 1'b1, 8'd0, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] check_len = '0;
   logic          chain_out;
   logic          shift_en, chain_in, done, flush_pass, flush_fail, stuck_det, stuck_val;
   logic [CW-1:0] first_err_idx;

   int n_chk = 0;
   int n_bad = 0;
   int wd    = 0;

   always #4 clk = ~clk;   // 125 MHz

   scan_flush_checker #(.CHAIN_LEN(N), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .check_len(check_len),
      .chain_out(chain_out), .shift_en(shift_en), .chain_in(chain_in),
      .done(done), .flush_pass(flush_pass), .flush_fail(flush_fail),
      .first_err_idx(first_err_idx), .stuck_det(stuck_det), .stuck_val(stuck_val)
   );

   // ---------------- chain model with fault injection ----------------
   logic [2:0]   fmode = '0;
   int           fpos  = 0;
   int           fflip = -1;
   logic         clr   = 1'b0;
   logic [N-1:0] ch;
   logic [N-1:0] q_eff;
   logic         ext_q;
   int           fc;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         q_eff[i] = ch[i];
         if (i == fpos) begin
            case (fmode)
               3'd1:    q_eff[i] = 1'b0;
               3'd2:    q_eff[i] = 1'b1;
               3'd3:    q_eff[i] = ~ch[i];
               default: q_eff[i] = ch[i];
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         ch    <= '0;
         ext_q <= 1'b0;
      end else if (shift_en) begin
         ch[0] <= chain_in;
         for (int i = 1; i < N; i++) ch[i] <= q_eff[i-1];
         ext_q <= q_eff[N-1];
      end
      fc <= shift_en ? fc + 1 : 0;
   end

   assign chain_out = ((fmode == 3'd4) ? ext_q : q_eff[N-1]) ^ ((fflip >= 0) && (fc == N + fflip));

   // ---------------- reporting ----------------
   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   // ---------------- one flush ----------------
   task automatic run_flush(input vec_t v, input int mid_start, input string tag);
      int k = 0;
      int bad_stim = 0;
      int len = (v.clen < 4) ? 4 : int'(v.clen);
      logic p0, f0, s0, v0;
      logic [CW-1:0] i0;
      @(negedge clk);
      fmode = v.mode; fpos = int'(v.pos); fflip = (v.flip == 8'd255) ? -1 : int'(v.flip);
      check_len = v.clen; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 4000; t++) begin
         if (done) break;
         if (shift_en) begin
            if (k == 0)   // R8: cleared in first flush cycle
               chk(!flush_pass && !flush_fail && !stuck_det && first_err_idx == 0, "R8", {tag, " cleared"},
                   int'(flush_pass) + int'(flush_fail), 0);
            if (chain_in != ((k >> 1) & 1)) bad_stim++;
            start = (k == mid_start);
            k++;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(bad_stim == 0, "R3", {tag, " stimulus errors"}, bad_stim, 0);
      chk(k == N + len, "R2", {tag, " shift_en cycles"}, k, N + len);
      chk(done == 1'b1, "R2", {tag, " done seen"}, int'(done), 1);
      chk(flush_pass == v.e_pass && flush_fail == !v.e_pass, "R5", {tag, " pass"}, int'(flush_pass), int'(v.e_pass));
      chk(first_err_idx == v.e_idx, "R6", {tag, " first idx"}, int'(first_err_idx), int'(v.e_idx));
      chk(stuck_det == v.e_stk && stuck_val == v.e_sv, "R7", {tag, " stuck"},
          int'({stuck_det, stuck_val}), int'({v.e_stk, v.e_sv}));
      p0 = flush_pass; f0 = flush_fail; i0 = first_err_idx; s0 = stuck_det; v0 = stuck_val;
      @(negedge clk);
      chk(!done && !shift_en, "R2", {tag, " done one cycle"}, int'(done), 0);
      chk(p0 == flush_pass && f0 == flush_fail && i0 == first_err_idx && s0 == stuck_det && v0 == stuck_val,
          "R8", {tag, " results held"}, int'(first_err_idx), int'(i0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!shift_en && !chain_in && !done && !flush_pass && !flush_fail && !stuck_det && !stuck_val
          && first_err_idx == 0, "R1", "reset outputs",
          int'({shift_en, chain_in, done, flush_pass, flush_fail, stuck_det, stuck_val}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!shift_en && !done, "R1", "idle after reset", int'(shift_en), 0);

      // table walk: R4 fill garbage from stuck/extra cells never counts before j = N
      for (int i = 0; i < NV; i++) begin
         run_flush(VECS[i], -1, $sformatf("vec%0d", i));
      end

      // R9: start while running is ignored
      run_flush(VECS[0], 3, "r9_restart");

      // R10: zero request clamps to 4 compared cycles
      run_flush('{3'd0, 4'd0, 8'd255, 8'd0, 1'b1, 8'd0, 1'b0, 1'b0}, -1, "r10_zero");

      // R4: a flip confined to the unchecked fill window has no effect
      run_flush('{3'd0, 4'd0, 8'd255, 8'd4, 1'b1, 8'd0, 1'b0, 1'b0}, -1, "r4_pre");
      fflip = -1;

      // R8: results hold while idle with no start
      repeat (5) @(negedge clk);
      chk(flush_pass && !flush_fail, "R8", "idle hold", int'(flush_pass), 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   // transient flip before comparison starts: drive the tail wrong during fill
   // by using a negative offset window through the stuck-free healthy chain
   initial begin
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (check_len == 8'd4 && shift_en && fc == N - 2 && fmode == 3'd0 && fflip < 0)
            force chain_out = ~((fmode == 3'd4) ? ext_q : q_eff[N-1]);
         else
            release chain_out;
      end
   end

endmodule